// File: doc/BRIEF.md
# Event Timer Global Register Block

This block is the shared register front end of a multi-channel event timer. It owns the free-running 64-bit tick counter, a read-only capability word, the global configuration and the per-channel interrupt status bits. A simple memory-mapped bus carries 32-bit reads and writes. Each 64-bit quantity appears as two 32-bit words: the low half at its offset and the high half at offset plus 4. Requests that fall inside a channel's register window are not served here. The block decodes them and hands them to the channel logic as a one-hot select, a write strobe, a word offset and write data. It returns the channel's read data on the bus.

The counter advances by one per clock while the global enable is set. While the enable is clear the counter holds, and either half can be loaded. When the enable goes from 0 to 1, the block sends a one-cycle arm pulse to each channel whose comparator is not all ones. When the enable goes from 1 to 0, it sends a one-cycle disarm pulse to every channel and clears all status bits. Channels report events, which latch into the status register. Software clears status bits by writing ones to them.

Top module: `evt_tmr_glb`

## Requirements
- R1: After reset the counter is 0, the enable and legacy-route bits are 0, the status bits are 0, and no arm, disarm or clear pulse is driven.
- R2: The word at 0x000 reads as follows: bits 7:0 hold revision 1, bits 12:8 hold NUM_CH-1, bit 13 is 1 (wide counter), bit 15 is 1 (legacy route capable), and all other bits are 0. The word at 0x004 reads TICK_FS. Writes to 0x000 and 0x004 change nothing.
- R3: While the enable is 1 and no counter half is being written, the counter increases by exactly 1 per clock, with carry from bit 31 into bit 32. While the enable is 0 it holds its value.
- R4: A write to 0x0F0 loads counter bits 31:0 and a write to 0x0F4 loads bits 63:32. The other half is kept, and no increment happens in that cycle. Reads of these two words return the counter halves.
- R5: A write to 0x010 stores only bit 0 (enable) and bit 1 (legacy route). Every other bit of 0x010 reads as 0. The word at 0x014 reads 0 and ignores writes.
- R6: A write that changes the enable from 0 to 1 drives ch_arm for one cycle, starting in the cycle after the write, with bit i set exactly when ch_cmp_allones[i] is 0.
- R7: A write that changes the enable from 1 to 0 drives every ch_disarm bit for one cycle, starting in the cycle after the write, and clears all status bits.
- R8: The status word at 0x020 has bit i set by ch_evt[i] while the enable is 1. A write of a one to bit i clears that bit, and if the bit was set, ch_irq_clr[i] pulses for one cycle in the next cycle. A zero written to a bit has no effect. The word at 0x024 reads 0.
- R9: An aligned access to 0x100 + 32*i + k with i < NUM_CH asserts only ch_sel[i] in the same cycle, with ch_offs = k, ch_wdata = write data and ch_wr = 1 for writes. A read returns that channel's ch_rdata word.
- R10: The following accesses select no channel, read 0 and change no state: a channel window with index NUM_CH or above, an address with bits 1:0 not zero, or any unmapped global offset.
- R11: Every request gets rsp_valid in the next cycle. The read data is the register state as it stood in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the 32-bit word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| main_count | output | 64 | Current tick counter |
| count_en | output | 1 | Global enable bit |
| legacy_route | output | 1 | Global legacy-route bit |
| ch_sel | output | NUM_CH | One-hot channel window select |
| ch_wr | output | 1 | Write strobe for the selected channel |
| ch_offs | output | 5 | Byte offset inside the channel window |
| ch_wdata | output | 32 | Write data to the channel |
| ch_rdata | input | NUM_CH*32 | Read data from each channel, slice i for channel i |
| ch_cmp_allones | input | NUM_CH | Channel comparator is all ones |
| ch_evt | input | NUM_CH | Channel event, sets its status bit |
| ch_arm | output | NUM_CH | One-cycle arm pulse on enable rise |
| ch_disarm | output | NUM_CH | One-cycle disarm pulse on enable fall |
| ch_irq_clr | output | NUM_CH | One-cycle interrupt clear pulse from a status write |

## Verification
A corrupted counter, enable or status register appears on the bus at the very next read of that word. The counter also drives main_count directly, so a missed or doubled increment shows at the ports within one clock. A wrong record of the previous enable value shows as a missing or unwanted arm or disarm pulse in the cycle right after the configuration write. Decode faults show in the same cycle as the request, as a wrong or multiple ch_sel, or as non-zero data returned for a hole in the map.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_CAP_LO,
    RG_CAP_HI,
    RG_CFG_LO,
    RG_CFG_HI,
    RG_STAT_LO,
    RG_STAT_HI,
    RG_CNT_LO,
    RG_CNT_HI,
    RG_CHAN
  } reg_sel_e;

  localparam int unsigned WIN_BASE     = 256;
  localparam int unsigned WIN_SHIFT    = 5;
  localparam int unsigned CFG_BITS     = 2;
  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned CFG_LEG_BIT  = 1;
  localparam logic [7:0]  CAP_REVISION = 8'h01;

  localparam logic [7:0] OFS_CAP_LO  = 8'h00;
  localparam logic [7:0] OFS_CAP_HI  = 8'h04;
  localparam logic [7:0] OFS_CFG_LO  = 8'h10;
  localparam logic [7:0] OFS_CFG_HI  = 8'h14;
  localparam logic [7:0] OFS_STAT_LO = 8'h20;
  localparam logic [7:0] OFS_STAT_HI = 8'h24;
  localparam logic [7:0] OFS_CNT_LO  = 8'hF0;
  localparam logic [7:0] OFS_CNT_HI  = 8'hF4;

endpackage

// File: rtl/evt_tmr_dec.sv
module evt_tmr_dec
  import evt_tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned NUM_CH = 3
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output reg_sel_e          sel,
  output logic [NUM_CH-1:0] ch_hit,
  output logic [4:0]        ch_offs
);

  localparam int unsigned       IDX_W      = ADDR_W - WIN_SHIFT;
  localparam logic [ADDR_W-1:0] WIN_BASE_A = ADDR_W'(WIN_BASE);
  localparam logic [IDX_W-1:0]  WIN_BASE_I = IDX_W'(WIN_BASE >> WIN_SHIFT);
  localparam logic [IDX_W-1:0]  NUM_CH_I   = IDX_W'(NUM_CH);

  logic             aligned;
  logic             in_win;
  logic [IDX_W-1:0] win_idx;
  logic             win_ok;

  assign aligned = (req_addr[1:0] == 2'b00);
  assign in_win  = (req_addr >= WIN_BASE_A);
  assign win_idx = req_addr[ADDR_W-1:WIN_SHIFT] - WIN_BASE_I;
  assign win_ok  = req_valid && aligned && in_win && (win_idx < NUM_CH_I);
  assign ch_offs = req_addr[4:0];

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_hit
    assign ch_hit[gi] = win_ok && (win_idx == IDX_W'(gi));
  end

  always_comb begin
    sel = RG_NONE;
    if (win_ok) begin
      sel = RG_CHAN;
    end else if (req_valid && aligned && !in_win) begin
      case (req_addr[7:0])
        OFS_CAP_LO:  sel = RG_CAP_LO;
        OFS_CAP_HI:  sel = RG_CAP_HI;
        OFS_CFG_LO:  sel = RG_CFG_LO;
        OFS_CFG_HI:  sel = RG_CFG_HI;
        OFS_STAT_LO: sel = RG_STAT_LO;
        OFS_STAT_HI: sel = RG_STAT_HI;
        OFS_CNT_LO:  sel = RG_CNT_LO;
        OFS_CNT_HI:  sel = RG_CNT_HI;
        default:     sel = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/evt_tmr_cnt.sv
module evt_tmr_cnt #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] count
);

  localparam int unsigned HI_W = CNT_W - 32;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (wr_lo) begin
      cnt_d[31:0] = wdata;
      cnt_ce      = 1'b1;
    end else if (wr_hi) begin
      cnt_d[CNT_W-1:32] = wdata[HI_W-1:0];
      cnt_ce            = 1'b1;
    end else if (run) begin
      cnt_d  = cnt_q + CNT_W'(1);
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/evt_tmr_stat.sv
module evt_tmr_stat #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              stop,
  input  logic              clr_wr,
  input  logic [NUM_CH-1:0] clr_mask,
  input  logic [NUM_CH-1:0] evt,
  output logic [NUM_CH-1:0] status,
  output logic [NUM_CH-1:0] irq_clr
);

  logic [NUM_CH-1:0] st_q, st_d;
  logic [NUM_CH-1:0] clr_q, clr_d;
  logic [NUM_CH-1:0] wipe;

  assign wipe = clr_wr ? clr_mask : '0;

  always_comb begin
    if (stop) begin
      st_d = '0;
    end else begin
      st_d = (st_q & ~wipe) | (run ? evt : '0);
    end
    clr_d = wipe & st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      clr_q <= '0;
    end else begin
      st_q  <= st_d;
      clr_q <= clr_d;
    end
  end

  assign status  = st_q;
  assign irq_clr = clr_q;

endmodule

// File: rtl/evt_tmr_glb.sv
module evt_tmr_glb
  import evt_tmr_pkg::*;
#(
  parameter int unsigned NUM_CH  = 3,
  parameter int unsigned ADDR_W  = 10,
  parameter logic [31:0] TICK_FS = 32'd10000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [63:0]          main_count,
  output logic                 count_en,
  output logic                 legacy_route,
  output logic [NUM_CH-1:0]    ch_sel,
  output logic                 ch_wr,
  output logic [4:0]           ch_offs,
  output logic [31:0]          ch_wdata,
  input  logic [NUM_CH*32-1:0] ch_rdata,
  input  logic [NUM_CH-1:0]    ch_cmp_allones,
  input  logic [NUM_CH-1:0]    ch_evt,
  output logic [NUM_CH-1:0]    ch_arm,
  output logic [NUM_CH-1:0]    ch_disarm,
  output logic [NUM_CH-1:0]    ch_irq_clr
);

  localparam logic [31:0] CAP_LO = {16'h0000, 1'b1, 1'b0, 1'b1,
                                    5'(NUM_CH - 1), CAP_REVISION};

  reg_sel_e          sel;
  logic [NUM_CH-1:0] ch_hit;
  logic              wr_any;
  logic              rd_any;

  logic [CFG_BITS-1:0] cfg_q, cfg_d;
  logic                cfg_ce;
  logic                en_rise, en_fall;
  logic [NUM_CH-1:0]   arm_q, arm_d;
  logic [NUM_CH-1:0]   disarm_q, disarm_d;
  logic [NUM_CH-1:0]   status_q;
  logic                rsp_v_q;
  logic [31:0]         rdata_q, rdata_d;
  logic [31:0]         ch_rd_or [NUM_CH+1];

  evt_tmr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .sel       (sel),
    .ch_hit    (ch_hit),
    .ch_offs   (ch_offs)
  );

  assign wr_any = req_valid && req_write;
  assign rd_any = req_valid && !req_write;

  evt_tmr_cnt #(.CNT_W(64)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (cfg_q[CFG_EN_BIT]),
    .wr_lo (wr_any && (sel == RG_CNT_LO)),
    .wr_hi (wr_any && (sel == RG_CNT_HI)),
    .wdata (req_wdata),
    .count (main_count)
  );

  evt_tmr_stat #(.NUM_CH(NUM_CH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cfg_q[CFG_EN_BIT]),
    .stop     (en_fall),
    .clr_wr   (wr_any && (sel == RG_STAT_LO)),
    .clr_mask (req_wdata[NUM_CH-1:0]),
    .evt      (ch_evt),
    .status   (status_q),
    .irq_clr  (ch_irq_clr)
  );

  // global configuration: masked merge, only CFG_BITS are storage
  always_comb begin
    cfg_ce  = wr_any && (sel == RG_CFG_LO);
    cfg_d   = cfg_ce ? req_wdata[CFG_BITS-1:0] : cfg_q;
    en_rise = cfg_ce && !cfg_q[CFG_EN_BIT] &&  req_wdata[CFG_EN_BIT];
    en_fall = cfg_ce &&  cfg_q[CFG_EN_BIT] && !req_wdata[CFG_EN_BIT];
    arm_d    = en_rise ? ~ch_cmp_allones : '0;
    disarm_d = en_fall ? {NUM_CH{1'b1}} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_ce) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q    <= '0;
      disarm_q <= '0;
    end else begin
      arm_q    <= arm_d;
      disarm_q <= disarm_d;
    end
  end

  // channel read data merge
  assign ch_rd_or[0] = '0;
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_rd
    assign ch_rd_or[gi+1] = ch_rd_or[gi] |
                            (ch_hit[gi] ? ch_rdata[gi*32 +: 32] : 32'h0);
  end

  always_comb begin
    rdata_d = 32'h0;
    if (rd_any) begin
      case (sel)
        RG_CAP_LO:  rdata_d = CAP_LO;
        RG_CAP_HI:  rdata_d = TICK_FS;
        RG_CFG_LO:  rdata_d = 32'(cfg_q);
        RG_STAT_LO: rdata_d = 32'(status_q);
        RG_CNT_LO:  rdata_d = main_count[31:0];
        RG_CNT_HI:  rdata_d = main_count[63:32];
        RG_CHAN:    rdata_d = ch_rd_or[NUM_CH];
        default:    rdata_d = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
    end else begin
      rsp_v_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (req_valid) begin
      rdata_q <= rdata_d;
    end
  end

  assign rsp_valid    = rsp_v_q;
  assign rsp_rdata    = rdata_q;
  assign count_en     = cfg_q[CFG_EN_BIT];
  assign legacy_route = cfg_q[CFG_LEG_BIT];
  assign ch_sel       = ch_hit;
  assign ch_wr        = wr_any && (sel == RG_CHAN);
  assign ch_wdata     = req_wdata;
  assign ch_arm       = arm_q;
  assign ch_disarm    = disarm_q;

endmodule

// File: rtl/evt_tmr_glb_chk.sv
module evt_tmr_glb_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [63:0]       main_count,
  input logic              count_en,
  input logic [NUM_CH-1:0] ch_sel,
  input logic [NUM_CH-1:0] ch_arm,
  input logic [NUM_CH-1:0] ch_disarm,
  input logic [NUM_CH-1:0] status_q
);

  logic cnt_wr;
  assign cnt_wr = req_valid && req_write &&
                  ((req_addr == ADDR_W'(12'h0F0)) || (req_addr == ADDR_W'(12'h0F4)));

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !cnt_wr) |=> $stable(main_count)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !cnt_wr) |=> (main_count == $past(main_count) + 64'd1)); // R3

  AST_ARM_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_arm != '0) |-> (count_en && !$past(count_en))); // R6

  AST_DISARM_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(count_en) |-> ((&ch_disarm) && (status_q == '0))); // R7

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel)); // R9

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11

endmodule

bind evt_tmr_glb evt_tmr_glb_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_evt_tmr_glb.sv
module sim_evt_tmr_glb;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NCH        = 3;
  localparam logic [31:0] TFS        = 32'd10000000;

  logic              clk;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [9:0]        req_addr;
  logic [31:0]       req_wdata;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [63:0]       main_count;
  logic              count_en, legacy_route;
  logic [NCH-1:0]    ch_sel;
  logic              ch_wr;
  logic [4:0]        ch_offs;
  logic [31:0]       ch_wdata;
  logic [NCH*32-1:0] ch_rdata;
  logic [NCH-1:0]    ch_cmp_allones, ch_evt;
  logic [NCH-1:0]    ch_arm, ch_disarm, ch_irq_clr;

  int n_chk  = 0;
  int n_fail = 0;

  evt_tmr_glb #(.NUM_CH(NCH), .ADDR_W(10), .TICK_FS(TFS)) u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // channel stand-in: answers with a tag of channel index and offset
  for (genvar gi = 0; gi < NCH; gi++) begin : g_stub
    assign ch_rdata[gi*32 +: 32] = ch_sel[gi] ? (32'hC0DE0000 | (gi << 8) | 32'(ch_offs)) : 32'h0;
  end

  // reference state derived from the requirements
  logic [63:0]    mdl_cnt;
  logic           mdl_en, mdl_leg;
  logic [NCH-1:0] mdl_st;
  logic           bw;
  assign bw = req_valid && req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdl_cnt <= '0; mdl_en <= 1'b0; mdl_leg <= 1'b0; mdl_st <= '0;
    end else begin
      if (bw && req_addr == 10'h0F0)      mdl_cnt <= {mdl_cnt[63:32], req_wdata};
      else if (bw && req_addr == 10'h0F4) mdl_cnt <= {req_wdata, mdl_cnt[31:0]};
      else if (mdl_en)                    mdl_cnt <= mdl_cnt + 64'd1;
      if (bw && req_addr == 10'h010) begin
        mdl_en  <= req_wdata[0];
        mdl_leg <= req_wdata[1];
      end
      if (bw && req_addr == 10'h010 && mdl_en && !req_wdata[0])
        mdl_st <= '0;
      else
        mdl_st <= (mdl_st & ~((bw && req_addr == 10'h020) ? req_wdata[NCH-1:0] : '0))
                  | (mdl_en ? ch_evt : '0);
    end
  end

  function automatic logic [31:0] cap_lo_exp();
    return 32'h1 | (32'(NCH - 1) << 8) | (32'h1 << 13) | (32'h1 << 15);
  endfunction

  function automatic logic [31:0] exp_read(input logic [9:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a >= 10'h100) begin
      if (((a - 10'h100) >> 5) < NCH)
        return 32'hC0DE0000 | (32'((a - 10'h100) >> 5) << 8) | 32'(a[4:0]);
      return 32'h0;
    end
    case (a)
      10'h000: return cap_lo_exp();
      10'h004: return TFS;
      10'h010: return {30'h0, mdl_leg, mdl_en};
      10'h020: return 32'(mdl_st);
      10'h0F0: return mdl_cnt[31:0];
      10'h0F4: return mdl_cnt[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
  endtask

  task automatic do_read(input logic [9:0] a, input string req);
    logic [31:0] e;
    drive(1'b0, a, 32'h0);
    e = exp_read(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_rdata == e, req, {31'h0, rsp_valid, rsp_rdata}, {32'h1, e});
  endtask

  task automatic do_write(input logic [9:0] a, input logic [31:0] d);
    drive(1'b1, a, d);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  localparam logic [9:0] PICK [12] = '{10'h000, 10'h004, 10'h010, 10'h014, 10'h020, 10'h024,
                                      10'h0F0, 10'h0F4, 10'h108, 10'h130, 10'h160, 10'h002};

  initial begin
    int unsigned sd;
    sd = $urandom(32'd1234);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    ch_cmp_allones = '0; ch_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(main_count == 64'h0, "R1 count", main_count, 64'h0);
    chk(!count_en && !legacy_route, "R1 cfg", {count_en, legacy_route}, 0);
    chk(ch_arm == 0 && ch_disarm == 0 && ch_irq_clr == 0, "R1 pulses",
        {ch_arm, ch_disarm, ch_irq_clr}, 0);
    do_read(10'h020, "R1 status");

    // R2 capability
    do_read(10'h000, "R2 cap lo");
    do_read(10'h004, "R2 cap hi");
    do_write(10'h000, 32'hFFFFFFFF);
    do_write(10'h004, 32'h0);
    do_read(10'h000, "R2 cap lo after write");
    do_read(10'h004, "R2 cap hi after write");

    // R5 masked config
    do_write(10'h010, 32'hFFFFFFFC);
    do_read(10'h010, "R5 cfg masked");
    do_write(10'h010, 32'h2);
    chk(legacy_route && !count_en, "R5 legacy bit", {count_en, legacy_route}, 2'b01);
    do_write(10'h014, 32'hFFFFFFFF);
    do_read(10'h014, "R5 cfg hi");
    do_read(10'h010, "R5 cfg after hi write");

    // R4 / R3 counter load while frozen
    do_write(10'h0F0, 32'hFFFFFFFE);
    do_write(10'h0F4, 32'h00000001);
    repeat (5) @(negedge clk);
    chk(main_count == 64'h1FFFFFFFE, "R3 frozen", main_count, 64'h1FFFFFFFE);
    do_read(10'h0F0, "R4 cnt lo");
    do_read(10'h0F4, "R4 cnt hi");

    // R6 enable rise arms channels with a live comparator
    ch_cmp_allones = 3'b010;
    do_write(10'h010, 32'h3);
    chk(ch_arm == 3'b101, "R6 arm pulse", ch_arm, 3'b101);
    @(negedge clk);
    chk(ch_arm == 3'b000, "R6 arm one cycle", ch_arm, 0);

    // R3 counting with carry out of bit 31
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(main_count == mdl_cnt, "R3 running", main_count, mdl_cnt);
    end
    chk(main_count[63:32] == 32'h2, "R3 carry", main_count, mdl_cnt);
    do_read(10'h0F0, "R11 cnt lo while running");

    // R8 status set and write-one-to-clear
    ch_evt = 3'b011;
    @(negedge clk);
    ch_evt = 3'b000;
    do_read(10'h020, "R8 status set");
    do_write(10'h020, 32'h5);
    chk(ch_irq_clr == 3'b001, "R8 clear pulse", ch_irq_clr, 3'b001);
    do_read(10'h020, "R8 status after clear");
    do_read(10'h024, "R8 status hi");

    // R9 channel windows
    for (int i = 0; i < NCH; i++) begin
      drive(1'b1, 10'(10'h100 + i*32 + 8), 32'hA5A50000 + i);
      #1;
      chk(ch_sel == NCH'(1 << i) && ch_wr && ch_offs == 5'd8 && ch_wdata == 32'hA5A50000 + i,
          "R9 window write", {ch_sel, ch_wr, ch_offs}, {NCH'(1 << i), 1'b1, 5'd8});
      @(negedge clk);
      req_valid = 1'b0;
      do_read(10'(10'h100 + i*32 + 16), "R9 window read");
    end

    // R10 holes
    drive(1'b1, 10'h160, 32'h1);
    #1;
    chk(ch_sel == 0 && !ch_wr, "R10 no select beyond count", {ch_sel, ch_wr}, 0);
    @(negedge clk);
    req_valid = 1'b0;
    do_read(10'h160, "R10 channel beyond count");
    do_read(10'h102, "R10 misaligned");
    do_read(10'h030, "R10 unmapped");
    do_write(10'h012, 32'h0);
    chk(count_en, "R10 misaligned cfg write ignored", count_en, 1);

    // R7 enable fall
    ch_evt = 3'b100;
    @(negedge clk);
    ch_evt = 3'b000;
    do_write(10'h010, 32'h0);
    chk(ch_disarm == 3'b111, "R7 disarm pulse", ch_disarm, 3'b111);
    do_read(10'h020, "R7 status cleared");
    do_read(10'h0F0, "R7 frozen lo");
    do_read(10'h0F0, "R7 frozen lo again");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [9:0]  a;
      logic [31:0] d;
      logic        was_en;
      a = PICK[$urandom_range(0, 11)];
      d = $urandom();
      ch_cmp_allones = NCH'($urandom());
      ch_evt = NCH'($urandom());
      if ($urandom_range(0, 2) == 0) begin
        was_en = mdl_en;
        if (a == 10'h0F4) d = d & 32'h0000000F;
        if (a == 10'h0F0) d = d | 32'hFFFFFF00;
        do_write(a, d);
        ch_evt = '0;
        if (a == 10'h010) begin
          chk(ch_arm == ((!was_en && d[0]) ? ~ch_cmp_allones : '0), "R6 random arm",
              ch_arm, (!was_en && d[0]) ? ~ch_cmp_allones : '0);
          chk(ch_disarm == ((was_en && !d[0]) ? '1 : '0), "R7 random disarm",
              ch_disarm, (was_en && !d[0]) ? 3'b111 : 3'b000);
        end
      end else begin
        do_read(a, "R11 random read");
        ch_evt = '0;
      end
      chk(main_count == mdl_cnt, "R3 random count", main_count, mdl_cnt);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule